// File: doc/BRIEF.md
# Block Cipher Job Control Registers

This block is the register front end of a DMA-driven block-cipher accelerator. Software uses a 32-bit register bus to program a source address, a destination address, a byte count, a 128-bit key and a 128-bit initial vector. It then writes a control word that launches the job. The block checks the job parameters and sends a one-cycle start request to an external cipher/DMA datapath. While the job runs, the register payload is held steady. When the datapath signals completion, the block clears the busy indication and raises a completion flag.

Completion is visible in two ways. The start bit of the control register reads back as a busy flag, so software can poll it. There is also a maskable interrupt register. That register collects completion events from this channel, from a second cipher channel and from a nonvolatile-store unit, and combines them into one interrupt line. The cipher rounds and the bus-master engine sit outside this block.

Top module: `cipher_job_regs`

## Requirements
- R1: After reset, every register reads zero, `eng_start` is 0 and `irq` is 0.
- R2: A control write (offset 0x00) with bit0=1 while idle, and with valid parameters, does four things. It sets bit0 (busy), which reads back as 1. It drives `eng_start` high for exactly one cycle, starting at the clock edge that takes the write. It holds the stored mode bits on the engine outputs: bit1 encrypt, bit2 writable key, bit3 destination coherent, bit4 source coherent, bit5 CBC.
- R3: While busy, an `eng_done` pulse clears control bit0 and sets interrupt-register bit16.
- R4: A start request is rejected if the length is not a multiple of 16, is zero, or if the source (0x10) or destination (0x14) is not 16-byte aligned. A rejected request leaves bit0 at 0, gives no `eng_start`, and sets sticky error bit6 of the control register. Bit6 clears on the next accepted start or on a control write with bit6=1.
- R5: Lengths up to and including 16384 bytes are accepted. Longer lengths are rejected as in R4.
- R6: In the interrupt register (0x08), bits 0..2 are disable bits for channel A, channel B and the store unit. Bits 16..18 are their completion flags. Writing 1 to a flag clears it. `irq` is the OR of each flag ANDed with the inverse of its disable bit.
- R7: Writing 0x00070007 to the interrupt register disables all three sources, clears all flags and drops `irq`.
- R8: While bit0 is 1, the block ignores writes to source, destination, length (0x18), key (0x30..0x3C) and IV (0x40..0x4C), as well as control writes.
- R9: Key words read back as zero but reach `eng_key`, with word k at 0x30+4k driving bits [32k+31:32k]. IV words, source, destination and length read back as written.
- R10: A pulse on `ext_done_b` sets flag bit17, and a pulse on `ext_done_store` sets flag bit18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| eng_start | output | 1 | One-cycle job request to the datapath |
| eng_src | output | 32 | Source address |
| eng_dst | output | 32 | Destination address |
| eng_len | output | 32 | Byte count |
| eng_key | output | 128 | Cipher key |
| eng_iv | output | 128 | Initial vector |
| eng_encrypt | output | 1 | 1 = encrypt, 0 = decrypt |
| eng_cbc | output | 1 | 1 = CBC, 0 = ECB |
| eng_use_wkey | output | 1 | Use the writable key |
| eng_dst_coh | output | 1 | Destination coherent |
| eng_src_coh | output | 1 | Source coherent |
| eng_done | input | 1 | Job complete pulse from the datapath |
| ext_done_b | input | 1 | Completion pulse from channel B |
| ext_done_store | input | 1 | Completion pulse from the store unit |
| irq | output | 1 | Interrupt output |

## Verification
Job launch is driven from a table of lengths and addresses. The table includes the smallest legal block, the 16384-byte limit, one block past that limit, a length that is not a multiple of 16, a zero length, and a misaligned source and a misaligned destination. Each entry shows whether one limit check is wired in independently of the others. Accepted entries are carried through to completion so that busy clearing and flag W1C are seen on every run. Directed cases cover three further patterns: writes to the payload while busy, key read masking against what reaches the engine, and interrupt masking for each of the three sources, including the all-ones clear word.

// File: rtl/cipher_job_regs.sv
module cipher_job_regs #(
  parameter int AW         = 8,
  parameter int MAX_LEN    = 16384,
  parameter int ALIGN_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          eng_start,
  output logic [31:0]   eng_src,
  output logic [31:0]   eng_dst,
  output logic [31:0]   eng_len,
  output logic [127:0]  eng_key,
  output logic [127:0]  eng_iv,
  output logic          eng_encrypt,
  output logic          eng_cbc,
  output logic          eng_use_wkey,
  output logic          eng_dst_coh,
  output logic          eng_src_coh,
  input  logic          eng_done,
  input  logic          ext_done_b,
  input  logic          ext_done_store,
  output logic          irq
);

  localparam logic [AW-1:0] OFS_CTRL = AW'('h00);
  localparam logic [AW-1:0] OFS_INT  = AW'('h08);
  localparam logic [AW-1:0] OFS_SRC  = AW'('h10);
  localparam logic [AW-1:0] OFS_DST  = AW'('h14);
  localparam logic [AW-1:0] OFS_LEN  = AW'('h18);
  localparam logic [AW-1:0] OFS_KEY  = AW'('h30);
  localparam logic [AW-1:0] OFS_IV   = AW'('h40);
  localparam logic [31:0]   ALIGN_M  = (32'd1 << ALIGN_LOG2) - 32'd1;

  logic        busy, err;
  logic [4:0]  mode;
  logic [31:0] src, dst, len;
  logic [127:0] key, iv;
  logic [2:0]  idis, iflag;

  wire wr_ctrl  = reg_wr && reg_addr == OFS_CTRL;
  wire wr_int   = reg_wr && reg_addr == OFS_INT;
  wire req      = wr_ctrl && !busy && reg_wdata[0];
  wire params_ok = ((len & ALIGN_M) == 0) && len != 0 && len <= MAX_LEN &&
                   ((src & ALIGN_M) == 0) && ((dst & ALIGN_M) == 0);
  wire go       = req && params_ok;
  wire bad      = req && !params_ok;
  wire [2:0] ev = {ext_done_store, ext_done_b, busy && eng_done};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; err <= 1'b0; mode <= '0; eng_start <= 1'b0;
      src <= '0; dst <= '0; len <= '0; key <= '0; iv <= '0;
      idis <= '0; iflag <= '0;
    end else begin
      eng_start <= go;
      if (go) busy <= 1'b1;
      else if (busy && eng_done) busy <= 1'b0;
      if (wr_ctrl && !busy) mode <= reg_wdata[5:1];
      if (bad) err <= 1'b1;
      else if (go || (wr_ctrl && reg_wdata[6])) err <= 1'b0;
      if (reg_wr && !busy) begin
        if (reg_addr == OFS_SRC) src <= reg_wdata;
        if (reg_addr == OFS_DST) dst <= reg_wdata;
        if (reg_addr == OFS_LEN) len <= reg_wdata;
        for (int k = 0; k < 4; k++) begin
          if (reg_addr == OFS_KEY + AW'(4*k)) key[32*k +: 32] <= reg_wdata;
          if (reg_addr == OFS_IV  + AW'(4*k)) iv[32*k +: 32]  <= reg_wdata;
        end
      end
      if (wr_int) idis <= reg_wdata[2:0];
      iflag <= (iflag & ~(wr_int ? reg_wdata[18:16] : 3'b000)) | ev;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: reg_rdata = {25'd0, err, mode, busy};
      OFS_INT:  reg_rdata = {13'd0, iflag, 13'd0, idis};
      OFS_SRC:  reg_rdata = src;
      OFS_DST:  reg_rdata = dst;
      OFS_LEN:  reg_rdata = len;
      default: begin
        for (int k = 0; k < 4; k++)
          if (reg_addr == OFS_IV + AW'(4*k)) reg_rdata = iv[32*k +: 32];
      end
    endcase
  end

  assign eng_src      = src;
  assign eng_dst      = dst;
  assign eng_len      = len;
  assign eng_key      = key;
  assign eng_iv       = iv;
  assign eng_encrypt  = mode[0];
  assign eng_use_wkey = mode[1];
  assign eng_dst_coh  = mode[2];
  assign eng_src_coh  = mode[3];
  assign eng_cbc      = mode[4];
  assign irq          = |(iflag & ~idis);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy); // R2
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done) |=> (!busy && iflag[0])); // R3
  AST_BAD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (!busy && err && !eng_start)); // R4
  AST_LOCK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == OFS_SRC) |=> $stable(src)); // R8
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_int && reg_wdata[18:16] == 3'b111 && reg_wdata[2:0] == 3'b111 && ev == 3'b000)
      |=> (!irq && iflag == 3'b000)); // R7

endmodule

// File: tb/cipher_job_regs_tb.sv
module cipher_job_regs_tb;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic eng_start, eng_encrypt, eng_cbc, eng_use_wkey, eng_dst_coh, eng_src_coh, irq;
  logic [31:0] eng_src, eng_dst, eng_len;
  logic [127:0] eng_key, eng_iv;
  logic eng_done = 0, ext_done_b = 0, ext_done_store = 0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  cipher_job_regs u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start), .eng_src(eng_src),
    .eng_dst(eng_dst), .eng_len(eng_len), .eng_key(eng_key), .eng_iv(eng_iv),
    .eng_encrypt(eng_encrypt), .eng_cbc(eng_cbc), .eng_use_wkey(eng_use_wkey),
    .eng_dst_coh(eng_dst_coh), .eng_src_coh(eng_src_coh), .eng_done(eng_done),
    .ext_done_b(ext_done_b), .ext_done_store(ext_done_store), .irq(irq));

  // {len, src, dst, accepted}
  localparam logic [96:0] VEC [8] = '{
    {32'd16,    32'h1000, 32'h2000, 1'b1},
    {32'd16384, 32'h0010, 32'h8000, 1'b1},
    {32'd16400, 32'h0000, 32'h0000, 1'b0},
    {32'd24,    32'h0000, 32'h0000, 1'b0},
    {32'd32,    32'h1004, 32'h0000, 1'b0},
    {32'd32,    32'h0000, 32'h2008, 1'b0},
    {32'd0,     32'h0000, 32'h0000, 1'b0},
    {32'd4096,  32'h00A0, 32'h00B0, 1'b1}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h00, r); check("R1 ctrl", r, 0);
    rd(8'h08, r); check("R1 int", r, 0);
    rd(8'h10, r); check("R1 src", r, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 start", {31'd0, eng_start}, 0);

    foreach (VEC[i]) begin
      logic [31:0] vl, vs, vd; logic ok;
      {vl, vs, vd, ok} = VEC[i];
      wr(8'h10, vs); wr(8'h14, vd); wr(8'h18, vl);
      wr(8'h00, 32'h23);
      check(ok ? "R2 start pulse" : "R4 R5 no start", {31'd0, eng_start}, {31'd0, ok});
      rd(8'h00, r);
      check("R2 R4 busy bit", {31'd0, r[0]}, {31'd0, ok});
      check("R4 error bit", {31'd0, r[6]}, {31'd0, !ok});
      if (ok) begin
        check("R2 eng_len", eng_len, vl);
        check("R2 eng_src", eng_src, vs);
        check("R2 mode", {30'd0, eng_encrypt, eng_cbc}, 32'd3);
        @(negedge clk);
        check("R2 single pulse", {31'd0, eng_start}, 0);
        pulse(eng_done);
        rd(8'h00, r); check("R3 busy cleared", {31'd0, r[0]}, 0);
        rd(8'h08, r); check("R3 flag A", {31'd0, r[16]}, 1);
        check("R6 irq on", {31'd0, irq}, 1);
        wr(8'h08, 32'h10000);
        rd(8'h08, r); check("R6 W1C", {31'd0, r[16]}, 0);
        check("R6 irq off", {31'd0, irq}, 0);
      end
    end

    // R4 W1C of error bit
    wr(8'h18, 32'd8); wr(8'h00, 32'h1);
    rd(8'h00, r); check("R4 err set", {31'd0, r[6]}, 1);
    wr(8'h00, 32'h40);
    rd(8'h00, r); check("R4 err W1C", {31'd0, r[6]}, 0);

    // R9 key and IV
    wr(8'h30, 32'hDEADBEEF); wr(8'h3C, 32'h01234567);
    rd(8'h30, r); check("R9 key reads 0", r, 0);
    check("R9 key word0", eng_key[31:0], 32'hDEADBEEF);
    check("R9 key word3", eng_key[127:96], 32'h01234567);
    wr(8'h44, 32'hCAFEF00D);
    rd(8'h44, r); check("R9 iv readback", r, 32'hCAFEF00D);
    check("R9 iv word1", eng_iv[63:32], 32'hCAFEF00D);

    // R8 lockout while busy, decrypt ECB
    wr(8'h10, 32'h100); wr(8'h14, 32'h200); wr(8'h18, 32'd64);
    wr(8'h00, 32'h01);
    check("R2 decrypt ecb", {30'd0, eng_encrypt, eng_cbc}, 0);
    wr(8'h10, 32'h300); rd(8'h10, r); check("R8 src locked", r, 32'h100);
    wr(8'h18, 32'd32); rd(8'h18, r); check("R8 len locked", r, 32'd64);
    wr(8'h30, 32'h11111111); check("R8 key locked", eng_key[31:0], 32'hDEADBEEF);
    wr(8'h44, 32'h0); rd(8'h44, r); check("R8 iv locked", r, 32'hCAFEF00D);
    wr(8'h00, 32'h0); rd(8'h00, r); check("R8 ctrl locked", {31'd0, r[0]}, 1);
    pulse(eng_done);
    rd(8'h00, r); check("R3 done", {31'd0, r[0]}, 0);

    // R6 R10 masking of other sources
    wr(8'h08, 32'h00070002);
    pulse(ext_done_b);
    rd(8'h08, r); check("R10 flag B masked", r, 32'h00020002);
    check("R6 irq masked", {31'd0, irq}, 0);
    wr(8'h08, 32'h0);
    check("R6 irq unmasked", {31'd0, irq}, 1);
    wr(8'h08, 32'h00070007);
    rd(8'h08, r); check("R7 clear all", r, 32'h7);
    check("R7 irq off", {31'd0, irq}, 0);
    pulse(ext_done_store);
    rd(8'h08, r); check("R10 flag store", r, 32'h00040007);
    check("R6 store disabled", {31'd0, irq}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule